// File: doc/BRIEF.md
# Host Bridge Memory and I/O Address Decoder

This block sits behind the host bus of a bridge and decides, for every host request, which port owns it: local DRAM, the PCI port, the AGP port, or the bridge itself, which completes the request on the spot. A request arrives as a single-cycle strobe carrying a physical address wider than 32 bits, a write flag and an I/O flag. One clock later the block presents a one-hot target, a terminate flag and a flag that tells the host side to return all-zero read data.

Memory addresses at or above 4 GB are never passed on. The bridge completes them locally: write data is dropped and reads return zeros. Below 1 MB, the area from 0xC0000 to 0xFFFFF is cut into shadow segments. Each segment carries a two-bit access attribute, and that attribute decides whether an access goes to DRAM or to PCI. The legacy video window goes to PCI, or to AGP when a steering bit is set. Between 1 MB and a programmable top of DRAM, accesses go to DRAM. Everything from there up to 4 GB goes to PCI. The attributes, the top of DRAM and the video steering bit are loaded through a small register-write port.

Top module: `hb_addr_decode`

## Requirements
- R1: A request strobed on `req_valid` at a clock edge appears on `rsp_valid` at the following edge. When `rsp_valid` is low, `rsp_target` is zero.
- R2: When `rsp_valid` is high, exactly one bit of `rsp_target` is set. Bit 0 is DRAM, bit 1 is PCI, bit 2 is AGP and bit 3 is local termination. `rsp_term` equals bit 3.
- R3: A memory request whose address has any bit at position 32 or above set is routed to local termination and never to PCI or AGP.
- R4: Memory addresses 0x00000–0x9FFFF go to DRAM.
- R5: Memory addresses 0xA0000–0xBFFFF go to PCI while the video steering bit (register index 14, data bit 0) is 0, and to AGP while it is 1.
- R6: Shadow segment i (i = 0..11) covers 16 KB starting at 0xC0000 + i·0x4000. Segment 12 covers 0xF0000–0xFFFFF. Each segment's attribute is written at register index i through data bits [1:0]: 00 none, 01 read only, 10 write only, 11 read and write. An access goes to DRAM when the attribute permits its direction, and to PCI otherwise.
- R7: Register index 13, data bits [11:0], sets the top of DRAM T in MB units. Memory addresses from 0x100000 up to but excluding T·2^20 go to DRAM. Memory addresses from max(T·2^20, 0x100000) up to 2^32−1 go to PCI.
- R8: An I/O request with an address below 0x10003 goes to PCI, which covers the 3 bytes past 64 KB. Any higher I/O address is terminated locally.
- R9: After reset, all segment attributes are 00, T is 1 and the steering bit is 0. All outputs are low.
- R10: A register write to an index above 14 changes no routing decision.
- R11: `rsp_zero_rd` is high exactly when a response is terminated locally and the request was a read. Terminated writes have their data discarded and `rsp_zero_rd` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | ADDR_W | Physical address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | CFG_W | Register write data |
| rsp_valid | output | 1 | Decode result valid |
| rsp_target | output | 4 | One-hot destination |
| rsp_term | output | 1 | Request completed locally |
| rsp_zero_rd | output | 1 | Return all-zero data for this read |

## Verification
The assertions assume that `req_valid`, `req_io`, `req_write` and the address carry known values whenever the strobe is high. They also assume that a register write and a request that depends on it do not fall in the same cycle: when they do, the request is decoded with the old setting. The stimulus always places each register write at least one cycle ahead of the requests it affects. It drives every input to a defined value from time zero and sweeps every shadow segment under all four attributes, at both ends of each segment and in both directions. It also covers the 4 GB, top-of-DRAM, video and I/O boundaries under both steering settings.

// File: rtl/hb_addr_decode.sv
module hb_addr_decode #(
  parameter int ADDR_W = 36,
  parameter int SEG_KB = 16,
  parameter int TOM_W  = 12,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              rsp_valid,
  output logic [3:0]        rsp_target,
  output logic              rsp_term,
  output logic              rsp_zero_rd
);
  localparam int LO_SEGS = 192 / SEG_KB;
  localparam int NSEG    = LO_SEGS + 1;
  localparam int SEG_SH  = $clog2(SEG_KB * 1024);
  localparam int SIDX_W  = $clog2(NSEG);
  localparam logic [3:0] IDX_TOM = 4'(NSEG);
  localparam logic [3:0] IDX_VGA = 4'(NSEG + 1);
  localparam logic [3:0] T_DRAM = 4'b0001;
  localparam logic [3:0] T_PCI  = 4'b0010;
  localparam logic [3:0] T_AGP  = 4'b0100;
  localparam logic [3:0] T_TERM = 4'b1000;

  logic [1:0]       attr_q [NSEG];
  logic [TOM_W-1:0] tom_q;
  logic             vga_agp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) attr_q[i] <= 2'b00;
      tom_q     <= TOM_W'(1);
      vga_agp_q <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < NSEG; i++)
        if (cfg_idx == 4'(i)) attr_q[i] <= cfg_wdata[1:0];
      if (cfg_idx == IDX_TOM) tom_q     <= cfg_wdata[TOM_W-1:0];
      if (cfg_idx == IDX_VGA) vga_agp_q <= cfg_wdata[0];
    end
  end

  wire        above4g = |req_addr[ADDR_W-1:32];
  wire [31:0] a32     = req_addr[31:0];
  wire [31:0] seg_off = a32 - 32'h000C_0000;
  wire [31:0] tom_top = 32'({tom_q, 20'h0_0000});
  wire        io_ok   = req_addr < ADDR_W'(32'h0001_0003);

  logic [SIDX_W-1:0] seg_idx;
  logic [1:0]        seg_attr;
  logic              seg_ok;
  logic [3:0]        dec_tgt;

  always_comb begin
    seg_idx  = (a32 >= 32'h000F_0000) ? SIDX_W'(NSEG - 1) : seg_off[SEG_SH +: SIDX_W];
    seg_attr = attr_q[seg_idx];
    seg_ok   = req_write ? seg_attr[1] : seg_attr[0];
    if (req_io)                    dec_tgt = io_ok ? T_PCI : T_TERM;
    else if (above4g)              dec_tgt = T_TERM;
    else if (a32 < 32'h000A_0000)  dec_tgt = T_DRAM;
    else if (a32 < 32'h000C_0000)  dec_tgt = vga_agp_q ? T_AGP : T_PCI;
    else if (a32 < 32'h0010_0000)  dec_tgt = seg_ok ? T_DRAM : T_PCI;
    else if (a32 < tom_top)        dec_tgt = T_DRAM;
    else                           dec_tgt = T_PCI;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_target  <= 4'b0;
      rsp_zero_rd <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_target  <= req_valid ? dec_tgt : 4'b0;
      rsp_zero_rd <= req_valid && dec_tgt == T_TERM && !req_write;
    end
  end

  assign rsp_term = rsp_target[3];
endmodule

module hb_addr_decode_chk #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_io,
  input logic              rsp_valid,
  input logic [3:0]        rsp_target,
  input logic              rsp_term,
  input logic              rsp_zero_rd
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_target == 4'b0);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_target) == 1);
  a_r2_term_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_term == rsp_target[3]);
  a_r3_above4g: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && |req_addr[ADDR_W-1:32]) |=> rsp_target == 4'b1000);
  a_r4_low_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && req_addr < ADDR_W'(32'hA0000)) |=> rsp_target == 4'b0001);
  a_r8_io_never_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_io) |=> (rsp_target[0] == 1'b0 && rsp_target[2] == 1'b0));
  a_r11_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_zero_rd |-> (rsp_term && !$past(req_write)));
  a_r11_zero_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_term && !$past(req_write)) |-> rsp_zero_rd);
endmodule

bind hb_addr_decode hb_addr_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .req_io(req_io), .rsp_valid(rsp_valid),
  .rsp_target(rsp_target), .rsp_term(rsp_term), .rsp_zero_rd(rsp_zero_rd));

// File: tb/hb_addr_decode_bench.sv
`timescale 1ns/1ps
module hb_addr_decode_bench;
  localparam int AW = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic rsp_valid, rsp_term, rsp_zero_rd;
  logic [3:0] rsp_target;
  int total = 0, bad = 0;
  logic [1:0] m_attr [13];
  int m_tom = 1;
  logic m_vga = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hb_addr_decode u_hb_addr_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_io(req_io), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_term(rsp_term), .rsp_zero_rd(rsp_zero_rd));

  function automatic logic [3:0] model(logic [AW-1:0] a, logic wr, logic io);
    longint unsigned v = longint'(a);
    int s;
    logic [1:0] at;
    if (io) return (v < 64'h10003) ? 4'b0010 : 4'b1000;
    if (v >= 64'h1_0000_0000) return 4'b1000;
    if (v < 64'hA0000) return 4'b0001;
    if (v < 64'hC0000) return m_vga ? 4'b0100 : 4'b0010;
    if (v < 64'h100000) begin
      s = int'((v - 64'hC0000) / 64'h4000);
      if (s > 12) s = 12;
      at = m_attr[s];
      return (wr ? at[1] : at[0]) ? 4'b0001 : 4'b0010;
    end
    if (v < longint'(m_tom) * 64'h100000) return 4'b0001;
    return 4'b0010;
  endfunction

  task automatic cfg(int idx, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 13) m_attr[idx] = data[1:0];
    else if (idx == 13) m_tom = data & 12'hFFF;
    else if (idx == 14) m_vga = data[0];
  endtask

  task automatic req(logic [AW-1:0] a, logic wr, logic io, string tag);
    logic [3:0] et;
    logic ez;
    et = model(a, wr, io);
    ez = (et == 4'b1000) && !wr;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_io = io;
    @(negedge clk);
    req_valid = 1'b0;
    total++;
    if (!rsp_valid || rsp_target !== et || rsp_term !== et[3] || rsp_zero_rd !== ez) begin
      bad++;
      $display("FAIL %s addr=%h wr=%0b io=%0b: got v=%0b tgt=%b term=%0b zero=%0b, expected v=1 tgt=%b term=%0b zero=%0b",
               tag, a, wr, io, rsp_valid, rsp_target, rsp_term, rsp_zero_rd, et, et[3], ez);
    end
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_target !== 4'b0) begin
      bad++;
      $display("FAIL R1 idle after %s: got v=%0b tgt=%b, expected v=0 tgt=0000", tag, rsp_valid, rsp_target);
    end
  endtask

  initial begin
    for (int i = 0; i < 13; i++) m_attr[i] = 2'b00;
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_target !== 4'b0 || rsp_term !== 1'b0 || rsp_zero_rd !== 1'b0) begin
      bad++;
      $display("FAIL R9 outputs in reset: got v=%0b tgt=%b, expected all zero", rsp_valid, rsp_target);
    end
    rst_n = 1'b1;
    // R9: defaults route shadow, video and above-1MB to PCI
    req(36'h00C0000, 1'b0, 1'b0, "R9 seg default");
    req(36'h00F8000, 1'b1, 1'b0, "R9 seg default");
    req(36'h00A0000, 1'b0, 1'b0, "R9 vga default");
    req(36'h0100000, 1'b0, 1'b0, "R9 tom default");
    // R4
    req(36'h0000000, 1'b0, 1'b0, "R4 low");
    req(36'h009FFFF, 1'b1, 1'b0, "R4 low");
    // R6 sweep
    for (int s = 0; s < 13; s++)
      for (int at = 0; at < 4; at++) begin
        logic [AW-1:0] lo, hi;
        cfg(s, at);
        lo = (s == 12) ? 36'hF0000 : AW'(32'hC0000 + s * 32'h4000);
        hi = (s == 12) ? 36'hFFFFF : lo + 36'h3FFF;
        for (int w = 0; w < 2; w++) begin
          req(lo, w[0], 1'b0, "R6 seg low end");
          req(hi, w[0], 1'b0, "R6 seg high end");
        end
      end
    // R5
    for (int g = 0; g < 2; g++) begin
      cfg(14, g);
      req(36'h00A0000, 1'b0, 1'b0, "R5 vga");
      req(36'h00BFFFF, 1'b1, 1'b0, "R5 vga");
      req(36'h00C0000, 1'b0, 1'b0, "R5 vga edge");
    end
    // R10
    cfg(0, 1);
    cfg(15, 16'hFFFF);
    req(36'h00C0000, 1'b1, 1'b0, "R10 ignored idx");
    req(36'h00C0000, 1'b0, 1'b0, "R10 ignored idx");
    req(36'h00A0000, 1'b0, 1'b0, "R10 ignored idx");
    req(36'h0100000, 1'b0, 1'b0, "R10 ignored idx");
    // R7
    cfg(13, 16);
    req(36'h0100000, 1'b0, 1'b0, "R7 tom");
    req(36'h0FFFFFF, 1'b1, 1'b0, "R7 tom");
    req(36'h1000000, 1'b0, 1'b0, "R7 tom");
    req(36'h0FFFFFFFF, 1'b1, 1'b0, "R7 tom");
    cfg(13, 4095);
    req(36'h0FFEFFFFF, 1'b0, 1'b0, "R7 tom max");
    req(36'h0FFF00000, 1'b0, 1'b0, "R7 tom max");
    // R3 / R11
    req(36'h100000000, 1'b0, 1'b0, "R3 R11 above4g rd");
    req(36'h100000000, 1'b1, 1'b0, "R3 R11 above4g wr");
    req(36'hFFFFFFFFF, 1'b0, 1'b0, "R3 above4g top");
    req(36'h1000A0000, 1'b1, 1'b0, "R3 alias low");
    // R8
    req(36'h0000000, 1'b0, 1'b1, "R8 io");
    req(36'h000FFFF, 1'b1, 1'b1, "R8 io");
    req(36'h0010002, 1'b0, 1'b1, "R8 io edge");
    req(36'h0010003, 1'b0, 1'b1, "R8 R11 io beyond");
    req(36'h0010003, 1'b1, 1'b1, "R8 R11 io beyond wr");
    req(36'h100000000, 1'b0, 1'b1, "R8 io high");
    // R2 back-to-back
    @(negedge clk);
    req_valid = 1'b1; req_addr = 36'h0000100; req_write = 1'b0; req_io = 1'b0;
    @(negedge clk);
    total++;
    if (rsp_target !== 4'b0001) begin bad++; $display("FAIL R2 b2b first: got %b expected 0001", rsp_target); end
    req_addr = 36'h100000000;
    @(negedge clk);
    req_valid = 1'b0;
    total++;
    if (rsp_target !== 4'b1000 || rsp_zero_rd !== 1'b1) begin
      bad++; $display("FAIL R2 b2b second: got %b zero=%0b expected 1000 zero=1", rsp_target, rsp_zero_rd);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule